// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives a 12-bit successive-approximation conversion. It sets a parallel trial code on an external resistor ladder and reads one comparator bit back. Each decision leaves the block on a serial bit line as soon as it is resolved, most significant bit first, so that sample memory can store it. The trial register only serves the comparisons and is not the place where results are kept.

When no conversion is running, the same ladder is used for playback. Serial words arrive most significant bit first. The leading bits wait in a small holding buffer while the rest are shifted in. The full word is then written to the ladder code in a single cycle. A settling interval after each code change comes before every comparator sample.

Top module: `sar_conv_seq`

## Requirements
- R1: A one-cycle `conv_start_i` while idle raises `busy_o` and sets the ladder code to only the top bit (0x800 with the default width) in the next cycle.
- R2: After each trial code change the code is held for `SETTLE_CYC` cycles and one decide cycle. The comparator is sampled only in the decide cycle, and the code does not change during that cycle.
- R3: In the decide cycle, `cmp_hi_i` = 1 (trial above input) clears the bit under trial and `cmp_hi_i` = 0 keeps it. The bit of next lower weight is set for the next trial.
- R4: Every decision produces a one-cycle `ser_valid_o` pulse with `ser_bit_o` = NOT `cmp_hi_i`. There are exactly 12 pulses per conversion, MSB first. With an ideal comparator the 12 bits equal the input level.
- R5: `done_o` pulses together with the last serial bit, and `busy_o` is low in that cycle. The last bit comes 1 + 12*(SETTLE_CYC+1) cycles after the start edge (25 with the defaults).
- R6: `conv_start_i` is ignored while a conversion is running, so the running conversion keeps its timing and result.
- R7: Playback bits (`pb_valid_i`, `pb_bit_i`, MSB first) do not change the ladder code while a word is incomplete. The first 3 bits are buffered. On the 12th bit all 12 code bits are updated together in the next cycle.
- R8: `pb_valid_i` is ignored during a conversion: no bit is counted and no load happens. After the conversion the ladder shows the last playback code again.
- R9: After synchronous active-low reset the ladder code is 0, and `busy_o`, `done_o` and `ser_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_i | input | 1 | Start pulse for a conversion |
| cmp_hi_i | input | 1 | Comparator: 1 when the trial level exceeds the held input |
| dac_code_o | output | 12 | Parallel ladder code (trial code while busy, playback code otherwise) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse with the final decision |
| ser_bit_o | output | 1 | Resolved decision bit |
| ser_valid_o | output | 1 | Strobe for `ser_bit_o` |
| pb_bit_i | input | 1 | Playback serial data bit |
| pb_valid_i | input | 1 | Strobe for `pb_bit_i` |

## Verification
The bench uses the default parameters: 12-bit words, 3 buffered playback bits and one settle cycle. With these values each decision falls on every second cycle, so a decision that comes one cycle early or late is visible in the pulse positions. The ideal comparator model in the bench reaches the all-zero and all-one codes and both sides of the mid-scale boundary. Start and playback strobes injected partway through a conversion exercise the ignore paths.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes: included first in compile order.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DECIDE = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_trial_fsm.sv
// Trial-bit sequencer. Walks one bit per trial from MSB to LSB. It waits
// SETTLE_CYC cycles after each code change, then takes one comparator
// decision and streams that decision out.
// Assumes: SETTLE_CYC >= 1, WIDTH >= 2, and a comparator that is valid after settling.
module sar_trial_fsm
    import sar_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int SETTLE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_hi_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic             ser_bit_o,
    output logic             ser_valid_o,
    output logic             done_o
);
    localparam int IW  = $clog2(WIDTH);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam logic [SCW-1:0]   LAST_CNT = SCW'(SETTLE_CYC - 1);
    localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_e       state_q;
    logic [WIDTH-1:0] trial_q;
    logic [IW-1:0]    idx_q;
    logic [SCW-1:0]   cnt_q;
    logic [WIDTH-1:0] cur_mask;
    logic [WIDTH-1:0] kept;

    // Mask for the bit under trial, and the code with that bit decided.
    always_comb begin
        cur_mask = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;
        kept     = cmp_hi_i ? (trial_q & ~cur_mask) : trial_q;
    end

    // Sequencer: idle -> settle -> decide, repeated once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            trial_q     <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            ser_bit_o   <= 1'b0;
            ser_valid_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            ser_valid_o <= 1'b0;
            done_o      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        trial_q <= MSB_MASK;
                        idx_q   <= IW'(WIDTH - 1);
                        cnt_q   <= '0;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == LAST_CNT) begin
                        cnt_q   <= '0;
                        state_q <= ST_DECIDE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    ser_bit_o   <= ~cmp_hi_i;
                    ser_valid_o <= 1'b1;
                    if (idx_q == '0) begin
                        trial_q <= kept;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        trial_q <= kept | (cur_mask >> 1);
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_SETTLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign trial_o = trial_q;
    assign busy_o  = (state_q != ST_IDLE);

    // R1: a start while idle loads the top bit alone.
    assert_start_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (trial_q == MSB_MASK));
    // R2: the code seen by the comparator has not moved since the settle cycle.
    assert_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |-> $stable(trial_q));
    // R3: a high comparator clears the tried bit.
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && cmp_hi_i) |=> ((trial_q & $past(cur_mask)) == '0));
    // R3: a low comparator keeps the tried bit.
    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !cmp_hi_i) |=> ((trial_q & $past(cur_mask)) != '0));
    // R4: every serial strobe follows a decide cycle.
    assert_ser_from_decide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid_o |-> $past(state_q == ST_DECIDE));
    // R5: done comes with the last bit and the sequencer is idle again.
    assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ser_valid_o && !busy_o));
endmodule

// File: rtl/sar_play_assembler.sv
// Playback word assembler. Takes serial bits MSB first. The leading HOLD_BITS
// bits go into a holding buffer and the rest into a tail shifter. The whole
// word is loaded into the output code register in one cycle.
// Assumes: 2 <= HOLD_BITS <= WIDTH-2, and that bits are ignored while busy_i.
module sar_play_assembler #(
    parameter int WIDTH     = 12,
    parameter int HOLD_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             bit_i,
    input  logic             valid_i,
    output logic [WIDTH-1:0] code_o
);
    localparam int CW = $clog2(WIDTH);
    localparam int TW = WIDTH - HOLD_BITS;
    localparam logic [CW-1:0] LAST_POS = CW'(WIDTH - 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_BITS);

    logic [HOLD_BITS-1:0] hold_q;
    logic [TW-1:0]        tail_q;
    logic [CW-1:0]        cnt_q;
    logic [WIDTH-1:0]     code_q;
    logic                 take;
    logic [TW-1:0]        tail_next;

    // A bit is accepted only when no conversion owns the ladder.
    always_comb begin
        take      = valid_i && !busy_i;
        tail_next = {tail_q[TW-2:0], bit_i};
    end

    // Fill the buffer, then the tail, then load the complete word at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            code_q <= '0;
        end else if (take) begin
            if (cnt_q < HOLD_END) begin
                hold_q <= {hold_q[HOLD_BITS-2:0], bit_i};
            end else begin
                tail_q <= tail_next;
            end
            if (cnt_q == LAST_POS) begin
                code_q <= {hold_q, tail_next};
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign code_o = code_q;

    // R7: the output code changes only on the last bit of a word.
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && cnt_q == LAST_POS) |=> $stable(code_q));
    // R8: strobes during a conversion do not advance the bit count.
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cnt_q));
endmodule

// File: rtl/sar_conv_seq.sv
// Top level of the successive-approximation sequencer. Instantiates the
// trial sequencer and the playback assembler. The ladder shows the trial
// code during a conversion and the playback code otherwise.
// Assumes: the comparator settles within SETTLE_CYC cycles of a code change.
module sar_conv_seq #(
    parameter int WIDTH      = 12,
    parameter int HOLD_BITS  = 3,
    parameter int SETTLE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic             cmp_hi_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ser_bit_o,
    output logic             ser_valid_o,
    input  logic             pb_bit_i,
    input  logic             pb_valid_i
);
    logic [WIDTH-1:0] trial_code;
    logic [WIDTH-1:0] play_code;
    logic             busy;

    sar_trial_fsm #(
        .WIDTH      (WIDTH),
        .SETTLE_CYC (SETTLE_CYC)
    ) trial_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (conv_start_i),
        .cmp_hi_i    (cmp_hi_i),
        .trial_o     (trial_code),
        .busy_o      (busy),
        .ser_bit_o   (ser_bit_o),
        .ser_valid_o (ser_valid_o),
        .done_o      (done_o)
    );

    sar_play_assembler #(
        .WIDTH     (WIDTH),
        .HOLD_BITS (HOLD_BITS)
    ) play_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy),
        .bit_i   (pb_bit_i),
        .valid_i (pb_valid_i),
        .code_o  (play_code)
    );

    // Ladder ownership: the conversion while busy, playback otherwise.
    always_comb begin
        dac_code_o = busy ? trial_code : play_code;
    end

    assign busy_o = busy;
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;
    localparam int W        = 12;
    localparam int SETTLE   = 1;
    localparam int CONV_CYC = 1 + W * (SETTLE + 1);
    localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};
    localparam int NVEC = 8;
    // Each row: {input level, expected serial word}
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800},
        {12'h7FF, 12'h7FF}, {12'h001, 12'h001}, {12'hA5C, 12'hA5C},
        {12'h3E1, 12'h3E1}, {12'hFFE, 12'hFFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic pb_bit = 1'b0;
    logic pb_valid = 1'b0;
    logic [W-1:0] vin = '0;
    logic cmp_hi;
    logic [W-1:0] dac_code;
    logic busy, done, ser_bit, ser_valid;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Ideal comparator: high when the ladder level exceeds the held input.
    assign cmp_hi = (dac_code > vin);

    sar_conv_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_i (conv_start),
        .cmp_hi_i     (cmp_hi),
        .dac_code_o   (dac_code),
        .busy_o       (busy),
        .done_o       (done),
        .ser_bit_o    (ser_bit),
        .ser_valid_o  (ser_valid),
        .pb_bit_i     (pb_bit),
        .pb_valid_i   (pb_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One conversion, with optional start and playback strobes injected mid-way.
    task automatic run_conv(input logic [W-1:0] v, input logic [W-1:0] exp_word,
                            input bit poke_start, input bit poke_pb);
        logic [W-1:0] word;
        int nb, dc, misplaced;
        vin = v;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk(dac_code == MSB && busy, "R1", {busy, dac_code}, {1'b1, MSB});
        word = '0; nb = 0; dc = 0; misplaced = 0;
        for (int c = 2; c <= 60 && dc == 0; c++) begin
            if (poke_start && c == 8) conv_start = 1'b1;
            if (poke_pb) begin
                pb_valid = (c % 2 == 0);
                pb_bit   = 1'b1;
            end
            @(negedge clk);
            conv_start = 1'b0;
            pb_valid   = 1'b0;
            if (c == 3)
                chk(dac_code == ((v & MSB) | (MSB >> 1)), "R3", dac_code, (v & MSB) | (MSB >> 1));
            if (ser_valid) begin
                word = {word[W-2:0], ser_bit};
                nb++;
                if ((c - 1) % (SETTLE + 1) != 0) misplaced++;
            end
            if (done) begin
                dc = c;
                chk(!busy, "R5", busy, 0);
            end
        end
        chk(misplaced == 0, "R2", misplaced, 0);
        chk(word == exp_word, poke_start ? "R6" : "R4", word, exp_word);
        chk(nb == W, "R4", nb, W);
        chk(dc == CONV_CYC, poke_start ? "R6" : "R5", dc, CONV_CYC);
    endtask

    // Send one playback word MSB first and check the all-at-once load.
    task automatic send_word(input logic [W-1:0] w);
        logic [W-1:0] prev;
        prev = dac_code;
        for (int i = W - 1; i >= 0; i--) begin
            pb_bit   = w[i];
            pb_valid = 1'b1;
            @(negedge clk);
            pb_valid = 1'b0;
            if (i > 0) chk(dac_code == prev, "R7", dac_code, prev);
            else       chk(dac_code == w, "R7", dac_code, w);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(dac_code == '0 && !busy && !done && !ser_valid, "R9",
            {done, ser_valid, busy, dac_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        send_word(12'h5A3);

        // R4/R5 table walk
        for (int k = 0; k < NVEC; k++) begin
            run_conv(VEC[k][2*W-1:W], VEC[k][W-1:0], 1'b0, 1'b0);
            @(negedge clk);
        end

        // R8: after a conversion the ladder returns to the playback code
        chk(dac_code == 12'h5A3, "R8", dac_code, 12'h5A3);

        // R6: start during a conversion
        run_conv(12'h6C9, 12'h6C9, 1'b1, 1'b0);
        @(negedge clk);

        // R8: playback strobes during a conversion
        run_conv(12'h2B7, 12'h2B7, 1'b0, 1'b1);
        @(negedge clk);
        chk(dac_code == 12'h5A3, "R8", dac_code, 12'h5A3);
        send_word(12'h9C4);
        send_word(12'h001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule